// File: doc/BRIEF.md
# MicroWire serial transfer engine

A half-duplex serial master that sits behind a 16-bit register bus. Software first loads a transmit word into the data register. It then writes the control register. That one write chooses one of four select lines, asserts or releases it, sets how many bits to send and how many to receive, and can launch the transfer. The engine shifts the send bits out first, most significant bit first. It then clocks in the receive bits, which are packed at the low end of the receive word. Busy and data-ready flags in the control register let software poll for completion.

The serial clock rate comes from outside, as a one-cycle `tick_i` strobe from the clock-configuration block. Each tick moves the serial clock by one half period. Data goes out on the falling edge of the serial clock and is sampled on the rising edge. The select line stays asserted between commands for as long as software keeps the select-command bit set. This lets several words form one frame.

Top module: `mw_xfer_engine`

## Requirements
- R1: After reset, all select lines are deasserted, `sclk_o` and `sdo_o` are low, and the control register reads 0x0000.
- R2: Control register (index 1) fields: bit 15 data ready (read only), bit 14 busy (read only), bit 13 start (reads 0), bit 12 select command, bits 11:10 select index, bits 9:5 send bit count, bits 4:0 receive bit count. A write while idle stores bits 12:0, and they read back unchanged.
- R3: While the select command is 1, `cs_o[index]` is high and all other select lines are low. Writing the command as 0 drives every select line low. The line stays high across back-to-back commands that keep the command at 1.
- R4: Register index = byte address >> `ADDR_SHIFT`. A write to index 0 loads the transmit word, and a read of index 0 returns the receive word. Indices 2 to 6 read as 0, and writes to them change nothing.
- R5: The transmit word is left-aligned. An N-bit send puts bits 15 down to 16-N on `sdo_o`, bit 15 first. `sdo_o` changes only on falling serial-clock edges and is low outside the send phase.
- R6: The receive word is right-aligned. An N-bit receive returns the first sampled bit at bit N-1 and the last at bit 0, with the upper bits zero.
- R7: A command with both counts non-zero sends all of its send bits and then receives all of its receive bits. Each bit takes one full serial-clock period (two ticks).
- R8: Busy reads 1 starting in the cycle after an accepted start. It returns to 0 after the last falling serial-clock edge. A start with both counts zero does not set busy.
- R9: Data ready sets when a command with a non-zero receive count completes. It clears on a read of index 0 or on a new start. A send-only command leaves it at 0.
- R10: While busy, writes to index 0 and index 1 are ignored. The running command, the select lines and the stored fields are unaffected.
- R11: A send or receive count above 16 is treated as 16.
- R12: `sclk_o` idles low. It toggles only in a cycle that follows a `tick_i` pulse during a command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address of the register access |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i`, combinational |
| tick_i | input | 1 | Half-period strobe for the serial clock |
| sdi_i | input | 1 | Serial data from the device |
| sclk_o | output | 1 | Serial clock |
| sdo_o | output | 1 | Serial data to the device |
| cs_o | output | 4 | Select lines, high when asserted |

## Verification
The bench goes after the bit order at both ends. A send that started from bit 0, or a receive packed at the top of the word, shows up as a wrong captured word. It checks that the phases run in order. An engine that sampled during the send phase, or dropped a period at the phase change, gives the wrong rising-edge count and receive word. It writes both registers while a command runs. A design that honoured those writes would move the select line or corrupt the next send. It also covers the zero-count start, counts above 16 and back-to-back ticks. Wrong handling there leaves busy stuck, shifts up to 31 bits, or drops a clock edge.

// File: rtl/mw_pkg.sv
`timescale 1ns/1ps
package mw_pkg;
  localparam int DATA_W   = 16;
  localparam int CNT_W    = 5;
  localparam int NUM_CS   = 4;
  localparam int CS_IDX_W = 2;

  localparam int REG_DATA = 0;
  localparam int REG_CTRL = 1;

  // control register bit positions (software visible)
  localparam int BIT_START  = 13;
  localparam int BIT_CS_ON  = 12;
  localparam int CS_IDX_LSB = 10;
  localparam int WR_LSB     = 5;
  localparam int RD_LSB     = 0;

  typedef struct packed {
    logic                rdy;
    logic                busy;
    logic                start;
    logic                cs_on;
    logic [CS_IDX_W-1:0] cs_idx;
    logic [CNT_W-1:0]    wr_bits;
    logic [CNT_W-1:0]    rd_bits;
  } ctrl_t;

  function automatic logic [CNT_W-1:0] clamp_cnt(logic [CNT_W-1:0] c);
    return (c > CNT_W'(DATA_W)) ? CNT_W'(DATA_W) : c;
  endfunction
endpackage

// File: rtl/mw_bus_regs.sv
`timescale 1ns/1ps
module mw_bus_regs
  import mw_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int ADDR_SHIFT = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_en_i,
  input  logic                rd_en_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic                busy_i,
  input  logic                rdy_i,
  input  logic [DATA_W-1:0]   rx_word_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic [DATA_W-1:0]   tx_word_o,
  output logic                cs_on_o,
  output logic [CS_IDX_W-1:0] cs_idx_o,
  output logic [CNT_W-1:0]    wr_bits_o,
  output logic [CNT_W-1:0]    rd_bits_o,
  output logic                start_o,
  output logic                rx_pop_o
);
  logic [ADDR_W-1:0] idx;
  logic sel_data, sel_ctrl, wr_ok;
  logic [CNT_W-1:0] new_wr, new_rd;
  ctrl_t st;

  assign idx      = addr_i >> ADDR_SHIFT;
  assign sel_data = (idx == ADDR_W'(REG_DATA));
  assign sel_ctrl = (idx == ADDR_W'(REG_CTRL));
  assign wr_ok    = wr_en_i & ~busy_i;
  assign new_wr   = wdata_i[WR_LSB +: CNT_W];
  assign new_rd   = wdata_i[RD_LSB +: CNT_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_word_o <= '0;
      cs_on_o   <= 1'b0;
      cs_idx_o  <= '0;
      wr_bits_o <= '0;
      rd_bits_o <= '0;
    end else if (wr_ok) begin
      if (sel_data) tx_word_o <= wdata_i;
      if (sel_ctrl) begin
        cs_on_o   <= wdata_i[BIT_CS_ON];
        cs_idx_o  <= wdata_i[CS_IDX_LSB +: CS_IDX_W];
        wr_bits_o <= new_wr;
        rd_bits_o <= new_rd;
      end
    end
  end

  // start with nothing to shift is dropped
  assign start_o  = wr_ok & sel_ctrl & wdata_i[BIT_START] & ((new_wr | new_rd) != '0);
  assign rx_pop_o = rd_en_i & sel_data;

  always_comb begin
    st.rdy     = rdy_i;
    st.busy    = busy_i;
    st.start   = 1'b0;
    st.cs_on   = cs_on_o;
    st.cs_idx  = cs_idx_o;
    st.wr_bits = wr_bits_o;
    st.rd_bits = rd_bits_o;
    if (sel_data)      rdata_o = rx_word_i;
    else if (sel_ctrl) rdata_o = st;
    else               rdata_o = '0;
  end
endmodule

// File: rtl/mw_cs_ctrl.sv
`timescale 1ns/1ps
module mw_cs_ctrl
  import mw_pkg::*;
(
  input  logic                cs_on_i,
  input  logic [CS_IDX_W-1:0] cs_idx_i,
  output logic [NUM_CS-1:0]   cs_o
);
  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_o[g] = cs_on_i & (cs_idx_i == CS_IDX_W'(g));
  end
endmodule

// File: rtl/mw_shifter.sv
`timescale 1ns/1ps
module mw_shifter
  import mw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  wr_bits_i,
  input  logic [CNT_W-1:0]  rd_bits_i,
  input  logic [DATA_W-1:0] tx_word_i,
  input  logic              tick_i,
  input  logic              sdi_i,
  input  logic              rx_pop_i,
  output logic              busy_o,
  output logic              rdy_o,
  output logic              sclk_o,
  output logic              sdo_o,
  output logic [DATA_W-1:0] rx_word_o
);
  logic              busy_q, rdy_q, half_q, sclk_q, rd_cmd_q;
  logic [CNT_W-1:0]  wleft_q, rleft_q, wr_n, rd_n;
  logic [DATA_W-1:0] txsh_q, rxsh_q;
  logic              in_write, last_edge;

  assign wr_n      = clamp_cnt(wr_bits_i);
  assign rd_n      = clamp_cnt(rd_bits_i);
  assign in_write  = (wleft_q != '0);
  // falling edge that ends the final bit
  assign last_edge = half_q & (in_write ? ((wleft_q == CNT_W'(1)) && (rleft_q == '0))
                                        : (rleft_q == CNT_W'(1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      rdy_q    <= 1'b0;
      half_q   <= 1'b0;
      sclk_q   <= 1'b0;
      rd_cmd_q <= 1'b0;
      wleft_q  <= '0;
      rleft_q  <= '0;
      txsh_q   <= '0;
      rxsh_q   <= '0;
    end else if (start_i) begin
      busy_q   <= 1'b1;
      rdy_q    <= 1'b0;
      half_q   <= 1'b0;
      sclk_q   <= 1'b0;
      rd_cmd_q <= (rd_n != '0);
      wleft_q  <= wr_n;
      rleft_q  <= rd_n;
      txsh_q   <= tx_word_i;
      rxsh_q   <= '0;
    end else if (busy_q && tick_i) begin
      if (!half_q) begin
        sclk_q <= 1'b1;
        half_q <= 1'b1;
        if (!in_write) rxsh_q <= {rxsh_q[DATA_W-2:0], sdi_i};
      end else begin
        sclk_q <= 1'b0;
        half_q <= 1'b0;
        if (in_write) begin
          wleft_q <= wleft_q - CNT_W'(1);
          txsh_q  <= {txsh_q[DATA_W-2:0], 1'b0};
        end else begin
          rleft_q <= rleft_q - CNT_W'(1);
        end
        if (last_edge) begin
          busy_q <= 1'b0;
          rdy_q  <= rd_cmd_q;
        end
      end
    end else if (rx_pop_i) begin
      rdy_q <= 1'b0;
    end
  end

  assign busy_o    = busy_q;
  assign rdy_o     = rdy_q;
  assign sclk_o    = sclk_q;
  assign sdo_o     = busy_q & in_write & txsh_q[DATA_W-1];
  assign rx_word_o = rxsh_q;
endmodule

// File: rtl/mw_xfer_engine.sv
`timescale 1ns/1ps
module mw_xfer_engine
  import mw_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int ADDR_SHIFT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [15:0]       wdata_i,
  output logic [15:0]       rdata_o,
  input  logic              tick_i,
  input  logic              sdi_i,
  output logic              sclk_o,
  output logic              sdo_o,
  output logic [3:0]        cs_o
);
  logic                busy, rdy, start_go, rx_pop, cs_on;
  logic [CS_IDX_W-1:0] cs_idx;
  logic [CNT_W-1:0]    wr_bits, rd_bits;
  logic [DATA_W-1:0]   tx_word, rx_word;

  mw_bus_regs #(.ADDR_W(ADDR_W), .ADDR_SHIFT(ADDR_SHIFT)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
    .rd_en_i(rd_en_i), .wdata_i(wdata_i), .busy_i(busy), .rdy_i(rdy),
    .rx_word_i(rx_word), .rdata_o(rdata_o), .tx_word_o(tx_word),
    .cs_on_o(cs_on), .cs_idx_o(cs_idx), .wr_bits_o(wr_bits),
    .rd_bits_o(rd_bits), .start_o(start_go), .rx_pop_o(rx_pop)
  );

  mw_cs_ctrl u_cs (.cs_on_i(cs_on), .cs_idx_i(cs_idx), .cs_o(cs_o));

  mw_shifter u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_go),
    .wr_bits_i(wdata_i[WR_LSB +: CNT_W]), .rd_bits_i(wdata_i[RD_LSB +: CNT_W]),
    .tx_word_i(tx_word), .tick_i(tick_i), .sdi_i(sdi_i), .rx_pop_i(rx_pop),
    .busy_o(busy), .rdy_o(rdy), .sclk_o(sclk_o), .sdo_o(sdo_o),
    .rx_word_o(rx_word)
  );

  logic unused_cnt;
  assign unused_cnt = ^{wr_bits, rd_bits};
endmodule

// File: rtl/mw_xfer_engine_chk.sv
`timescale 1ns/1ps
module mw_xfer_engine_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic [3:0] cs_o,
  input logic       sclk_o,
  input logic       sdo_o,
  input logic       busy_i,
  input logic       rdy_i,
  input logic       start_i
);
  AST_CS_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(cs_o)); // R3
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni) !busy_i |-> !sclk_o); // R12
  AST_SCLK_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni) !tick_i |=> $stable(sclk_o)); // R12
  AST_SDO_QUIET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni) !busy_i |-> !sdo_o); // R5
  AST_SDO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) (busy_i && !tick_i) |=> $stable(sdo_o)); // R5
  AST_BUSY_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni) start_i |=> busy_i); // R8
  AST_RDY_CLEARED_BY_START: assert property (@(posedge clk_i) disable iff (!rst_ni) start_i |=> !rdy_i); // R9
  AST_CS_FROZEN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni) busy_i |=> $stable(cs_o)); // R10
endmodule

bind mw_xfer_engine mw_xfer_engine_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .cs_o(cs_o),
  .sclk_o(sclk_o), .sdo_o(sdo_o), .busy_i(busy), .rdy_i(rdy), .start_i(start_go)
);

// File: tb/tb_mw_xfer_engine.sv
`timescale 1ns/1ps
module tb_mw_xfer_engine;
  localparam int AW = 8;
  localparam int SH = 2;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic wr_en_i = 1'b0, rd_en_i = 1'b0, tick_i = 1'b0, sdi_i = 1'b0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic sclk_o, sdo_o;
  logic [3:0] cs_o;

  int checks = 0, fails = 0, gap = 2, tcnt = 0, rises = 0;
  bit done = 0, prev_sclk = 0;
  logic [15:0] cap = '0;
  bit sq[$];

  // reference model state
  bit m_busy = 0, m_rdy = 0, m_cscmd = 0, m_half = 0, m_sclk = 0, m_rdcmd = 0;
  logic [1:0] m_csidx = '0;
  logic [4:0] m_wc = '0, m_rc = '0;
  logic [15:0] m_tx = '0, m_rx = '0;
  int m_rleft = 0;
  bit m_q[$];

  mw_xfer_engine #(.ADDR_W(AW), .ADDR_SHIFT(SH)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
    .rd_en_i(rd_en_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .tick_i(tick_i),
    .sdi_i(sdi_i), .sclk_o(sclk_o), .sdo_o(sdo_o), .cs_o(cs_o)
  );

  always #10 clk_i = ~clk_i;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk_i) begin
    #2;
    tcnt++;
    if (tcnt >= gap) begin tick_i = 1'b1; tcnt = 0; end
    else tick_i = 1'b0;
  end

  always @(posedge clk_i) begin
    int idx, w, r;
    bit was_busy;
    if (!rst_ni) begin
      m_busy = 0; m_rdy = 0; m_cscmd = 0; m_csidx = 0; m_wc = 0; m_rc = 0;
      m_tx = 0; m_rx = 0; m_half = 0; m_sclk = 0; m_q.delete();
    end else begin
      idx = int'(addr_i) >> SH;
      was_busy = m_busy;
      if (rd_en_i && idx == 0) m_rdy = 0;
      if (wr_en_i && !was_busy) begin
        if (idx == 0) m_tx = wdata_i;
        else if (idx == 1) begin
          m_cscmd = wdata_i[12]; m_csidx = wdata_i[11:10];
          m_wc = wdata_i[9:5]; m_rc = wdata_i[4:0];
          w = (m_wc > 16) ? 16 : int'(m_wc);
          r = (m_rc > 16) ? 16 : int'(m_rc);
          if (wdata_i[13] && (w + r) > 0) begin
            m_busy = 1; m_rdy = 0; m_q.delete();
            for (int i = 0; i < w; i++) m_q.push_back(m_tx[15-i]);
            m_rleft = r; m_rx = 0; m_half = 0; m_sclk = 0; m_rdcmd = (r > 0);
          end
        end
      end
      if (was_busy && tick_i) begin
        if (!m_half) begin
          m_sclk = 1; m_half = 1;
          if (m_q.size() == 0) m_rx = {m_rx[14:0], sdi_i};
        end else begin
          m_sclk = 0; m_half = 0;
          if (m_q.size() > 0) void'(m_q.pop_front());
          else m_rleft--;
          if (m_q.size() == 0 && m_rleft == 0) begin m_busy = 0; m_rdy = m_rdcmd; end
        end
      end
    end
  end

  function automatic logic [15:0] exp_rdata(logic [AW-1:0] a);
    int idx = int'(a) >> SH;
    if (idx == 0) return m_rx;
    if (idx == 1) return {m_rdy, m_busy, 1'b0, m_cscmd, m_csidx, m_wc, m_rc};
    return 16'h0;
  endfunction

  // per-cycle comparison and device-side stimulus
  always @(negedge clk_i) begin
    if (rst_ni) begin
      chk("R3 cs_o", 32'(cs_o), m_cscmd ? 32'(1 << m_csidx) : 32'd0);
      chk("R12 sclk_o", 32'(sclk_o), 32'(m_sclk));
      chk("R5 sdo_o", 32'(sdo_o), (m_busy && m_q.size() > 0) ? 32'(m_q[0]) : 32'd0);
      chk("R2 rdata_o", 32'(rdata_o), 32'(exp_rdata(addr_i)));
    end
    if (sclk_o && !prev_sclk) begin
      rises++;
      cap = {cap[14:0], sdo_o};
      if (sq.size() > 0) void'(sq.pop_front());
    end
    prev_sclk = sclk_o;
    sdi_i = (sq.size() > 0) ? sq[0] : 1'b0;
  end

  task automatic bus_write(int idx, logic [15:0] d);
    @(posedge clk_i); #2;
    addr_i = AW'(idx << SH); wdata_i = d; wr_en_i = 1'b1;
    @(posedge clk_i); #2;
    wr_en_i = 1'b0;
  endtask

  task automatic bus_read(int idx, output logic [15:0] d);
    @(posedge clk_i); #2;
    addr_i = AW'(idx << SH); rd_en_i = 1'b1;
    @(negedge clk_i); d = rdata_o;
    @(posedge clk_i); #2;
    rd_en_i = 1'b0;
  endtask

  task automatic wait_idle();
    logic [15:0] v = 16'h4000;
    int n = 0;
    while (v[14] && n < 4000) begin bus_read(1, v); n++; end
  endtask

  task automatic load_dev(int pad, logic [15:0] word, int nbits);
    sq.delete();
    for (int i = 0; i < pad; i++) sq.push_back(1'b0);
    for (int i = nbits - 1; i >= 0; i--) sq.push_back(word[i]);
  endtask

  function automatic logic [15:0] ctl(bit st, bit on, int ci, int w, int r);
    return {2'b00, st, on, 2'(ci), 5'(w), 5'(r)};
  endfunction

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL R8 watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1'b1;
    chk("R1 cs after reset", 32'(cs_o), 0);
    chk("R1 sclk after reset", 32'(sclk_o), 0);
    chk("R1 sdo after reset", 32'(sdo_o), 0);
    bus_read(1, v); chk("R1 ctrl after reset", 32'(v), 0);

    // send only, 8 bits
    bus_write(0, 16'hA5C3);
    rises = 0; cap = 0;
    bus_write(1, ctl(1, 1, 2, 8, 0));
    chk("R3 cs asserted", 32'(cs_o), 32'h4);
    bus_read(1, v); chk("R8 busy set", 32'(v[14]), 1);
    wait_idle();
    chk("R5 sent byte", 32'(cap[7:0]), 32'hA5);
    chk("R7 send edges", rises, 8);
    bus_read(1, v); chk("R9 no ready after send", 32'(v[15]), 0);

    // receive only, 11 bits, select held
    load_dev(0, 16'h05A3, 11);
    bus_write(1, ctl(1, 1, 2, 0, 11));
    wait_idle();
    chk("R3 cs held across commands", 32'(cs_o), 32'h4);
    bus_read(1, v); chk("R9 ready set", 32'(v[15]), 1);
    bus_read(0, v); chk("R6 rx right aligned", 32'(v), 32'h05A3);
    bus_read(1, v); chk("R9 ready cleared by read", 32'(v[15]), 0);

    // send then receive, back-to-back ticks
    gap = 1;
    bus_write(0, 16'hB000);
    load_dev(4, 16'h0015, 5);
    rises = 0; cap = 0;
    bus_write(1, ctl(1, 1, 2, 4, 5));
    wait_idle();
    chk("R7 total edges", rises, 9);
    chk("R7 send precedes receive", 32'(cap[8:5]), 32'hB);
    bus_read(0, v); chk("R6 rx after send", 32'(v), 32'h0015);

    // writes while busy
    gap = 3;
    bus_write(0, 16'h1234);
    bus_write(1, ctl(1, 1, 2, 16, 0));
    bus_write(0, 16'hFFFF);
    bus_write(1, ctl(1, 0, 0, 1, 0));
    chk("R10 cs unaffected while busy", 32'(cs_o), 32'h4);
    wait_idle();
    bus_read(1, v); chk("R10 fields kept", 32'(v & 16'h1FFF), 32'(ctl(0, 1, 2, 16, 0)));
    rises = 0; cap = 0;
    bus_write(1, ctl(1, 1, 2, 16, 0));
    wait_idle();
    chk("R10 tx word kept", 32'(cap), 32'h1234);

    // release
    gap = 2;
    bus_write(1, ctl(0, 0, 2, 0, 0));
    chk("R3 cs released", 32'(cs_o), 0);

    // zero counts
    rises = 0;
    bus_write(1, ctl(1, 1, 1, 0, 0));
    chk("R3 cs index 1", 32'(cs_o), 32'h2);
    repeat (6) @(posedge clk_i);
    bus_read(1, v); chk("R8 zero count no busy", 32'(v[14]), 0);
    chk("R12 no clock for zero count", rises, 0);

    // clamp
    rises = 0;
    bus_write(1, ctl(1, 1, 1, 31, 0));
    wait_idle();
    chk("R11 count clamped", rises, 16);

    // field readback and unmapped indices
    bus_write(1, ctl(0, 1, 3, 7, 9));
    bus_read(1, v); chk("R2 ctrl readback", 32'(v), 32'h1CE9);
    chk("R3 cs index 3", 32'(cs_o), 32'h8);
    bus_write(3, 16'hFFFF);
    bus_read(3, v); chk("R4 index 3 reads zero", 32'(v), 0);
    bus_read(1, v); chk("R4 write to index 3 no effect", 32'(v), 32'h1CE9);
    bus_read(5, v); chk("R4 index 5 reads zero", 32'(v), 0);
    chk("R12 sclk idle low", 32'(sclk_o), 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule